// File: doc/BRIEF.md
# Interrupt and Exception Dispatcher

This block sits beside the control path of a 32-bit processor core. Each cycle it looks at the pending interrupt level, the raised and enabled interrupt lines, the current status word, the current PC and any synchronous exception request. From these it decides whether control is redirected. When it is, the block registers the new PC, the new status word, and the writes that save the interrupted PC and status into the core's save registers. It also pulses a one-cycle `taken` strobe.

Levels 2 and above each have a save-register pair and a vector of their own. A level-1 interrupt is not vectored directly. It is turned into a user, kernel or double exception, chosen by the status word, and a fixed cause code is written. Every target address can be relocated against a vector-base register. That register resets to its configured value, and the core can write it through a one-cycle load port.

Status word layout: bits [3:0] hold the current interrupt level, bit 4 is the exception-mode flag and bit 5 is the user-mode flag. The synchronous exception index uses this encoding:

| Index | Exception |
|---|---|
| 1 | window overflow, call depth 4 |
| 2 | window underflow, call depth 4 |
| 3 | window overflow, call depth 8 |
| 4 | window underflow, call depth 8 |
| 5 | window overflow, call depth 12 |
| 6 | window underflow, call depth 12 |
| 7 | kernel |
| 8 | user |
| 9 | double |
| 0, 10 to 15 | no vector configured |

Top module: `irq_dispatch`

## Requirements
- R1: While reset is held, the outputs are as follows. `taken` and all write strobes are 0. `pc_out` holds RESET_VEC (0x5FFF8000). `ps_out` is 0x1F when INT_OPT=1, or 0x10 otherwise. `vecbase_out` holds VECBASE_RST (0x5FFF8400).
- R2: An interrupt at `irq_level` L is accepted only when all three conditions hold. L is strictly greater than `ps_in[3:0]`. L is not above NLEVEL (default 3). The AND of level L's mask, `int_raised` and `int_enable` is non-zero. Default masks: level 1 is bits [7:0], level 2 is bits [15:8], level 3 is bits [23:16], level 4 is bits [31:24].
- R3: An accepted level L≥2 produces four results. The PC is saved with `save_pc_sel`=L and `ps_in` is saved with `save_ps_sel`=L. `ps_out` equals `ps_in` with bits [3:0] replaced by L and bit 4 set. `pc_out` is level L's vector (defaults: level 2 0x5FFF857C, level 3 0x5FFF859C).
- R4: An accepted level-1 interrupt writes cause code 4 (`cause_we`) and does not save the status word.
- R5: A level-1 interrupt arriving with `ps_in[4]` set goes to the double-exception vector (0x5FFF865C). The PC is saved to slot 0, the double-exception PC register, when HAS_DEPC=1, or to slot 1 otherwise.
- R6: A level-1 interrupt arriving with `ps_in[4]` clear saves the PC to slot 1. It goes to the user vector (0x5FFF863C) if `ps_in[5]` is set, or to the kernel vector (0x5FFF861C) otherwise. In both R5 and R6, `ps_out` is `ps_in` with bit 4 set.
- R7: With RELOC_EN=1, each target is the configured vector minus VECBASE_RST plus the current `vecbase_out`, computed modulo 2^32.
- R8: A synchronous exception whose index has a non-zero vector sets `pc_out` to that relocated vector and `ps_out` to `ps_in`. It saves nothing and writes no cause.
- R9: A synchronous exception whose index has vector 0 leaves `pc_out` and `ps_out` unchanged and does not raise `taken`.
- R10: When `exc_req` is high, no interrupt is taken in that cycle, even if the index is unconfigured.
- R11: For each accepted event, `taken` and the write strobes are high for exactly the one cycle after the inputs are sampled. Without an event, all strobes are 0 and `pc_out`/`ps_out` hold their values.
- R12: A `vb_we` pulse loads `vb_wdata` into the vector base, effective from the next cycle. Targets computed in the same cycle as the write use the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_level | input | 3 | Pending interrupt level |
| int_raised | input | 32 | Raised interrupt lines |
| int_enable | input | 32 | Interrupt enable mask |
| ps_in | input | 32 | Current status word |
| pc_in | input | 32 | Current PC |
| exc_req | input | 1 | Synchronous exception request |
| exc_idx | input | 4 | Exception index |
| vb_we | input | 1 | Vector-base load strobe |
| vb_wdata | input | 32 | Vector-base load value |
| taken | output | 1 | One-cycle redirect strobe |
| pc_out | output | 32 | New PC |
| ps_out | output | 32 | New status word |
| save_pc_we | output | 1 | Save-PC write strobe |
| save_pc_sel | output | 3 | Save-PC slot (0 = double-exception PC) |
| save_pc_data | output | 32 | PC value to save |
| save_ps_we | output | 1 | Save-status write strobe |
| save_ps_sel | output | 3 | Save-status slot (level) |
| save_ps_data | output | 32 | Status value to save |
| cause_we | output | 1 | Cause register write strobe |
| cause_data | output | 32 | Cause value (level-1 interrupt code) |
| vecbase_out | output | 32 | Current vector base |

## Verification
The assertions assume that `irq_level`, `ps_in` and `exc_req` are held stable across the sampling edge. They also assume that the interrupt-level field of `ps_in` is a plain number, so a comparison against it means what R2 says. The stimulus changes inputs only on the falling edge. It keeps the status level in the range 0 to 3, so that acceptance and rejection both occur often. Directed cases then reach the boundary conditions: a level equal to the current level, a level above NLEVEL, and a mask with no overlap.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int XW    = 32;
  localparam int NINT  = 32;
  localparam int LW    = 3;
  localparam int NSLOT = 1 << LW;
  localparam int EW    = 4;
  localparam int NEXC  = 1 << EW;

  localparam int PS_EXCM = 4;
  localparam int PS_UM   = 5;
  localparam logic [XW-1:0] CAUSE_L1 = 32'd4;

  typedef enum logic [EW-1:0] {
    EX_NONE  = 4'd0,
    EX_WOV4  = 4'd1, EX_WUN4  = 4'd2,
    EX_WOV8  = 4'd3, EX_WUN8  = 4'd4,
    EX_WOV12 = 4'd5, EX_WUN12 = 4'd6,
    EX_KERN  = 4'd7, EX_USER  = 4'd8, EX_DBL = 4'd9
  } exc_e;

  typedef struct packed {
    logic          taken;
    logic [XW-1:0] pc;
    logic [XW-1:0] ps;
    logic          spc_we;
    logic [LW-1:0] spc_sel;
    logic [XW-1:0] spc_d;
    logic          sps_we;
    logic [LW-1:0] sps_sel;
    logic [XW-1:0] sps_d;
    logic          cause_we;
  } disp_t;

  function automatic logic [XW-1:0] reloc_vec(input logic [XW-1:0] v,
      input logic [XW-1:0] base_rst, input logic [XW-1:0] base_now, input logic en);
    return en ? (v - base_rst + base_now) : v;
  endfunction

  function automatic logic [NEXC*XW-1:0] default_exc_tbl();
    logic [NEXC*XW-1:0] t;
    t = '0;
    for (int i = 0; i < 6; i++)
      t[(i+1)*XW +: XW] = 32'h5FFF8400 + 32'(i) * 32'h40;
    t[int'(EX_KERN)*XW +: XW] = 32'h5FFF861C;
    t[int'(EX_USER)*XW +: XW] = 32'h5FFF863C;
    t[int'(EX_DBL)*XW  +: XW] = 32'h5FFF865C;
    return t;
  endfunction

  function automatic logic [NSLOT*XW-1:0] default_lvl_vec();
    logic [NSLOT*XW-1:0] t;
    t = '0;
    t[2*XW +: XW] = 32'h5FFF857C;
    t[3*XW +: XW] = 32'h5FFF859C;
    return t;
  endfunction

  function automatic logic [NSLOT*NINT-1:0] default_lvl_mask();
    logic [NSLOT*NINT-1:0] t;
    t = '0;
    for (int l = 1; l <= 4; l++)
      t[l*NINT + (l-1)*8 +: 8] = 8'hFF;
    return t;
  endfunction
endpackage

// File: rtl/irqd_accept.sv
module irqd_accept
  import irqd_pkg::*;
#(
  parameter int NLEVEL = 3,
  parameter logic [NSLOT*NINT-1:0] LVL_MASK_TBL = default_lvl_mask()
) (
  input  logic [LW-1:0]   level,
  input  logic [NINT-1:0] raised,
  input  logic [NINT-1:0] enable,
  input  logic [3:0]      cur_lvl,
  output logic            accept
);
  logic [NSLOT-1:0] lvl_hit;

  for (genvar g = 0; g < NSLOT; g++) begin : g_lvl
    if (g >= 1 && g <= NLEVEL) begin : g_on
      assign lvl_hit[g] = |(LVL_MASK_TBL[g*NINT +: NINT] & raised & enable);
    end else begin : g_off
      assign lvl_hit[g] = 1'b0;
    end
  end

  assign accept = lvl_hit[level] && ({1'b0, level} > cur_lvl);
endmodule

// File: rtl/irqd_route.sv
module irqd_route
  import irqd_pkg::*;
#(
  parameter bit HAS_DEPC = 1'b1,
  parameter bit RELOC_EN = 1'b1,
  parameter logic [XW-1:0] VECBASE_RST = 32'h5FFF8400,
  parameter logic [NEXC*XW-1:0]  EXC_VEC_TBL = default_exc_tbl(),
  parameter logic [NSLOT*XW-1:0] LVL_VEC_TBL = default_lvl_vec()
) (
  input  logic          exc_req,
  input  logic [EW-1:0] exc_idx,
  input  logic          irq_ok,
  input  logic [LW-1:0] level,
  input  logic [XW-1:0] ps_in,
  input  logic [XW-1:0] pc_in,
  input  logic [XW-1:0] vecbase,
  input  logic [XW-1:0] hold_pc,
  input  logic [XW-1:0] hold_ps,
  output disp_t         nx,
  output logic          exc_hit,
  output logic          exc_miss
);
  logic [XW-1:0] exc_vec, lvl_vec, l1_vec;
  logic          in_excm;

  assign exc_vec  = EXC_VEC_TBL[exc_idx*XW +: XW];
  assign lvl_vec  = LVL_VEC_TBL[level*XW +: XW];
  assign in_excm  = ps_in[PS_EXCM];
  assign exc_hit  = exc_req && (exc_vec != '0);
  assign exc_miss = exc_req && (exc_vec == '0);

  always_comb begin
    if (in_excm)
      l1_vec = EXC_VEC_TBL[int'(EX_DBL)*XW +: XW];
    else if (ps_in[PS_UM])
      l1_vec = EXC_VEC_TBL[int'(EX_USER)*XW +: XW];
    else
      l1_vec = EXC_VEC_TBL[int'(EX_KERN)*XW +: XW];
  end

  always_comb begin
    nx    = '0;
    nx.pc = hold_pc;
    nx.ps = hold_ps;
    if (exc_req) begin
      if (exc_hit) begin
        nx.taken = 1'b1;
        nx.pc    = reloc_vec(exc_vec, VECBASE_RST, vecbase, RELOC_EN);
        nx.ps    = ps_in;
      end
    end else if (irq_ok) begin
      nx.taken  = 1'b1;
      nx.spc_we = 1'b1;
      nx.spc_d  = pc_in;
      if (level > LW'(1)) begin
        nx.spc_sel = level;
        nx.sps_we  = 1'b1;
        nx.sps_sel = level;
        nx.sps_d   = ps_in;
        nx.ps      = {ps_in[XW-1:PS_EXCM+1], 1'b1, 1'b0, level};
        nx.pc      = reloc_vec(lvl_vec, VECBASE_RST, vecbase, RELOC_EN);
      end else begin
        nx.cause_we = 1'b1;
        nx.spc_sel  = (in_excm && HAS_DEPC) ? LW'(0) : LW'(1);
        nx.ps       = ps_in | (XW'(1) << PS_EXCM);
        nx.pc       = reloc_vec(l1_vec, VECBASE_RST, vecbase, RELOC_EN);
      end
    end
  end
endmodule

// File: rtl/irqd_vecbase.sv
module irqd_vecbase
  import irqd_pkg::*;
#(
  parameter logic [XW-1:0] VECBASE_RST = 32'h5FFF8400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [XW-1:0] wdata,
  output logic [XW-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)  base <= VECBASE_RST;
    else if (we) base <= wdata;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NLEVEL   = 3,
  parameter bit HAS_DEPC = 1'b1,
  parameter bit INT_OPT  = 1'b1,
  parameter bit RELOC_EN = 1'b1,
  parameter logic [XW-1:0] RESET_VEC   = 32'h5FFF8000,
  parameter logic [XW-1:0] VECBASE_RST = 32'h5FFF8400,
  parameter logic [NEXC*XW-1:0]    EXC_VEC_TBL  = default_exc_tbl(),
  parameter logic [NSLOT*XW-1:0]   LVL_VEC_TBL  = default_lvl_vec(),
  parameter logic [NSLOT*NINT-1:0] LVL_MASK_TBL = default_lvl_mask()
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   irq_level,
  input  logic [NINT-1:0] int_raised,
  input  logic [NINT-1:0] int_enable,
  input  logic [XW-1:0]   ps_in,
  input  logic [XW-1:0]   pc_in,
  input  logic            exc_req,
  input  logic [EW-1:0]   exc_idx,
  input  logic            vb_we,
  input  logic [XW-1:0]   vb_wdata,
  output logic            taken,
  output logic [XW-1:0]   pc_out,
  output logic [XW-1:0]   ps_out,
  output logic            save_pc_we,
  output logic [LW-1:0]   save_pc_sel,
  output logic [XW-1:0]   save_pc_data,
  output logic            save_ps_we,
  output logic [LW-1:0]   save_ps_sel,
  output logic [XW-1:0]   save_ps_data,
  output logic            cause_we,
  output logic [XW-1:0]   cause_data,
  output logic [XW-1:0]   vecbase_out
);
  localparam logic [XW-1:0] PS_RST = INT_OPT ? 32'h1F : 32'h10;

  logic  irq_ok;
  logic  exc_hit;
  logic  exc_miss;
  disp_t nx, r;

  irqd_accept #(.NLEVEL(NLEVEL), .LVL_MASK_TBL(LVL_MASK_TBL)) u_accept (
    .level(irq_level), .raised(int_raised), .enable(int_enable),
    .cur_lvl(ps_in[3:0]), .accept(irq_ok)
  );

  irqd_vecbase #(.VECBASE_RST(VECBASE_RST)) u_vb (
    .clk(clk), .rst_n(rst_n), .we(vb_we), .wdata(vb_wdata), .base(vecbase_out)
  );

  irqd_route #(
    .HAS_DEPC(HAS_DEPC), .RELOC_EN(RELOC_EN), .VECBASE_RST(VECBASE_RST),
    .EXC_VEC_TBL(EXC_VEC_TBL), .LVL_VEC_TBL(LVL_VEC_TBL)
  ) u_route (
    .exc_req(exc_req), .exc_idx(exc_idx), .irq_ok(irq_ok), .level(irq_level),
    .ps_in(ps_in), .pc_in(pc_in), .vecbase(vecbase_out),
    .hold_pc(r.pc), .hold_ps(r.ps), .nx(nx), .exc_hit(exc_hit), .exc_miss(exc_miss)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r    <= '0;
      r.pc <= RESET_VEC;
      r.ps <= PS_RST;
    end else begin
      r <= nx;
    end
  end

  assign taken        = r.taken;
  assign pc_out       = r.pc;
  assign ps_out       = r.ps;
  assign save_pc_we   = r.spc_we;
  assign save_pc_sel  = r.spc_sel;
  assign save_pc_data = r.spc_d;
  assign save_ps_we   = r.sps_we;
  assign save_ps_sel  = r.sps_sel;
  assign save_ps_data = r.sps_d;
  assign cause_we     = r.cause_we;
  assign cause_data   = CAUSE_L1;
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
  import irqd_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] irq_level,
  input logic [XW-1:0] ps_in,
  input logic          exc_req,
  input logic          vb_we,
  input logic [XW-1:0] vb_wdata,
  input logic          taken,
  input logic [XW-1:0] pc_out,
  input logic [XW-1:0] ps_out,
  input logic          save_pc_we,
  input logic          save_ps_we,
  input logic [LW-1:0] save_ps_sel,
  input logic          cause_we,
  input logic [XW-1:0] cause_data,
  input logic [XW-1:0] vecbase_out,
  input logic          exc_miss
);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (!save_pc_we && !save_ps_we && !cause_we));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (pc_out == $past(pc_out) && ps_out == $past(ps_out)));

  a_r3_level_ps: assert property (@(posedge clk) disable iff (!rst_n)
    save_ps_we |-> (taken && save_ps_sel >= LW'(2) && ps_out[3:0] == {1'b0, save_ps_sel}
                    && ps_out[PS_EXCM]));

  a_r2_above: assert property (@(posedge clk) disable iff (!rst_n)
    save_ps_we |-> ({1'b0, $past(irq_level)} > $past(ps_in[3:0])));

  a_r4_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |-> (taken && save_pc_we && !save_ps_we && cause_data == CAUSE_L1
                  && ps_out[PS_EXCM]));

  a_r10_prio: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (!cause_we && !save_ps_we && !save_pc_we));

  a_r9_miss: assert property (@(posedge clk) disable iff (!rst_n)
    exc_miss |=> !taken);

  a_r12_vb: assert property (@(posedge clk) disable iff (!rst_n)
    vb_we |=> (vecbase_out == $past(vb_wdata)));
endmodule

bind irq_dispatch irqd_chk u_chk (.*);

// File: tb/test_irq_dispatch.sv
`timescale 1ns/1ps
module test_irq_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  irq_level = '0;
  logic [31:0] int_raised = '0, int_enable = '0, ps_in = '0, pc_in = '0;
  logic        exc_req = 1'b0;
  logic [3:0]  exc_idx = '0;
  logic        vb_we = 1'b0;
  logic [31:0] vb_wdata = '0;
  logic        taken, save_pc_we, save_ps_we, cause_we;
  logic [31:0] pc_out, ps_out, save_pc_data, save_ps_data, cause_data, vecbase_out;
  logic [2:0]  save_pc_sel, save_ps_sel;

  irq_dispatch i_irq_dispatch (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] ev [16];
  logic [31:0] lv [8];
  logic [31:0] lm [8];
  logic [31:0] mvb, mpc, mps;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rel(input logic [31:0] v);
    return v + (mvb - 32'h5FFF8400);
  endfunction

  task automatic step(input logic [2:0] lvl, input logic [31:0] rs, input logic [31:0] en,
                      input logic [31:0] ps, input logic [31:0] pc, input logic er,
                      input logic [3:0] ei, input logic vw, input logic [31:0] vd);
    string tag;
    logic e_tk, e_spw, e_ssw, e_cw;
    logic [2:0] e_spsel;
    logic [31:0] e_pc, e_ps;
    @(negedge clk);
    irq_level = lvl; int_raised = rs; int_enable = en; ps_in = ps; pc_in = pc;
    exc_req = er; exc_idx = ei; vb_we = vw; vb_wdata = vd;
    e_tk = 0; e_spw = 0; e_ssw = 0; e_cw = 0; e_spsel = 0;
    e_pc = mpc; e_ps = mps; tag = "R11";
    if (er) begin
      if (ev[ei] != 0) begin
        tag = "R8"; e_tk = 1; e_pc = rel(ev[ei]); e_ps = ps;
      end else tag = (lvl != 0) ? "R10" : "R9";
    end else if ({1'b0, lvl} > ps[3:0] && lvl <= 3 && (lm[lvl] & rs & en) != 0) begin
      e_tk = 1; e_spw = 1;
      if (lvl >= 2) begin
        tag = "R3"; e_ssw = 1; e_spsel = lvl;
        e_pc = rel(lv[lvl]); e_ps = (ps & ~32'h1F) | 32'h10 | 32'(lvl);
      end else begin
        e_cw = 1; e_ps = ps | 32'h10;
        if (ps[4]) begin tag = "R5"; e_spsel = 0; e_pc = rel(ev[9]); end
        else begin tag = "R6"; e_spsel = 1; e_pc = rel(ps[5] ? ev[8] : ev[7]); end
      end
    end else if (lvl != 0) tag = "R2";
    @(posedge clk); #1;
    chk(tag, "taken", 32'(taken), 32'(e_tk));
    chk(tag, "pc_out", pc_out, e_pc);
    chk(tag, "ps_out", ps_out, e_ps);
    chk(tag, "save_pc_we", 32'(save_pc_we), 32'(e_spw));
    chk(tag, "save_ps_we", 32'(save_ps_we), 32'(e_ssw));
    chk(tag, "cause_we", 32'(cause_we), 32'(e_cw));
    if (e_spw) begin
      chk(tag, "save_pc_sel", 32'(save_pc_sel), 32'(e_spsel));
      chk(tag, "save_pc_data", save_pc_data, pc);
    end
    if (e_ssw) begin
      chk("R3", "save_ps_sel", 32'(save_ps_sel), 32'(lvl));
      chk("R3", "save_ps_data", save_ps_data, ps);
    end
    if (e_cw) chk("R4", "cause_data", cause_data, 32'd4);
    mpc = e_pc; mps = e_ps;
    if (vw) mvb = vd;
    chk("R12", "vecbase_out", vecbase_out, mvb);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog act=0 exp=1");
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd5171);
    for (int i = 0; i < 16; i++) ev[i] = 0;
    for (int i = 1; i <= 6; i++) ev[i] = 32'h5FFF8400 + 32'(i - 1) * 32'h40;
    ev[7] = 32'h5FFF861C; ev[8] = 32'h5FFF863C; ev[9] = 32'h5FFF865C;
    for (int i = 0; i < 8; i++) begin lv[i] = 0; lm[i] = 0; end
    lv[2] = 32'h5FFF857C; lv[3] = 32'h5FFF859C;
    lm[1] = 32'h000000FF; lm[2] = 32'h0000FF00; lm[3] = 32'h00FF0000; lm[4] = 32'hFF000000;
    mvb = 32'h5FFF8400; mpc = 32'h5FFF8000; mps = 32'h1F;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "taken", 32'(taken), 0);
    chk("R1", "pc_out", pc_out, 32'h5FFF8000);
    chk("R1", "ps_out", ps_out, 32'h1F);
    chk("R1", "vecbase_out", vecbase_out, 32'h5FFF8400);
    chk("R1", "strobes", 32'({save_pc_we, save_ps_we, cause_we}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: boundaries
    step(3'd2, '1, '1, 32'h2, 32'h100, 0, 0, 0, 0);          // equal level
    step(3'd4, '1, '1, 32'h0, 32'h104, 0, 0, 0, 0);          // above NLEVEL
    step(3'd3, 32'h0000FFFF, '1, 32'h0, 32'h108, 0, 0, 0, 0); // no overlap
    step(3'd3, '1, 32'h00FF0000, 32'h0, 32'h10C, 0, 0, 0, 0); // accepted
    // R3 explicit target
    chk("R3", "pc_out lvl3", pc_out, 32'h5FFF859C);
    // R5 / R6 / R4
    step(3'd1, 32'h1, 32'h1, 32'h10, 32'h200, 0, 0, 0, 0);
    chk("R5", "double vec", pc_out, 32'h5FFF865C);
    step(3'd1, 32'h1, 32'h1, 32'h20, 32'h204, 0, 0, 0, 0);
    chk("R6", "user vec", pc_out, 32'h5FFF863C);
    step(3'd1, 32'h1, 32'h1, 32'h00, 32'h208, 0, 0, 0, 0);
    chk("R6", "kernel vec", pc_out, 32'h5FFF861C);
    // R10: exception request blocks an acceptable interrupt
    step(3'd2, '1, '1, 32'h0, 32'h300, 1, 4'd0, 0, 0);
    step(3'd2, '1, '1, 32'h0, 32'h304, 1, 4'd3, 0, 0);
    // R9: unconfigured indices
    step(3'd0, 0, 0, 32'h0, 32'h308, 1, 4'd12, 0, 0);
    // R12 / R7: write then relocate
    step(3'd0, 0, 0, 32'h0, 32'h30C, 1, 4'd1, 1, 32'h10000000);
    chk("R12", "old base used", pc_out, 32'h5FFF8400);
    step(3'd0, 0, 0, 32'h0, 32'h310, 1, 4'd2, 0, 0);
    chk("R7", "relocated", pc_out, 32'h10000040);
    step(3'd2, 32'h100, 32'h100, 32'h1, 32'h314, 0, 0, 0, 0);
    chk("R7", "relocated lvl2", pc_out, 32'h1000017C);
    step(3'd0, 0, 0, 32'h0, 32'h318, 0, 0, 1, 32'h5FFF8400);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] p, rs, en;
      p = $urandom;
      p[3:0] = 4'($urandom_range(0, 3));
      rs = ($urandom_range(0, 3) == 0) ? 32'hFFFFFFFF : $urandom;
      en = ($urandom_range(0, 1) == 0) ? 32'hFFFFFFFF : $urandom;
      step(3'($urandom_range(0, 7)), rs, en, p, $urandom,
           ($urandom_range(0, 3) == 0), 4'($urandom_range(0, 15)),
           ($urandom_range(0, 19) == 0), $urandom);
    end

    done = 1'b1;
    finish_run();
  end
endmodule